// File: doc/BRIEF.md
# LED Breathing and Blinking Controller

This block drives a single LED pin from an 8-bit pulse-width modulator. The pin is high while the free-running PWM counter is below the active duty value. The PWM counter and a reloadable delay counter are both advanced by a tick strobe. Two tick strobes arrive as single-cycle enables, a slow one and a fast one, and a select bit chooses between them. The clock sources themselves are outside the block.

In blinking mode, the delay counter divides the selected tick by (LD + 1) before it reaches the PWM counter. The duty value is taken directly from the MIN input. In breathing mode, the PWM counter runs on the selected tick without division. The duty value then ramps between MIN and MAX. It dwells HD periods at the top and LD periods at the bottom.

The ramp rate comes from two packed 32-bit words, each holding eight 4-bit fields. One word gives the step sizes and the other gives the intervals. The field in use is picked from the current duty value. In the asymmetric option, the ramp direction also takes part in that choice, so rising and falling ramps use separate fields.

Top module: `led_pulse_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the PWM counter, the delay counter, the interval counter and the hold counter. It loads the ramp duty with `duty_min` and enters the rising phase, so the first PWM period after reset carries duty `duty_min`.
- R2: `led_out` is 1 exactly while the 8-bit PWM counter is below the active duty value. A duty of 0 keeps `led_out` at 0.
- R3: `clk_sel` = 1 takes `fast_en` as the tick, and `clk_sel` = 0 takes `slow_en`. The unselected strobe has no effect.
- R4: In blinking mode (`blink_mode` = 1), the PWM counter advances once per (`hold_lo` + 1) ticks. With `hold_lo` = 0 it advances on every tick. The first tick after reset advances it at once.
- R5: In blinking mode, the duty value is `duty_min` and the PWM counter is 8 bits wide, so one PWM period spans 256 × (`hold_lo` + 1) ticks.
- R6: In breathing mode, the duty value changes only at the end of a PWM period. While rising it increases by the selected step, and while falling it decreases by the selected step. A change happens once every (interval + 1) periods, where step and interval are the selected fields.
- R7: When a rising step would reach or pass `duty_max`, the duty is set to `duty_max`. It is held for `hold_hi` periods and the ramp then falls. If `hold_hi` = 0 it falls at once.
- R8: When a falling step would reach or pass `duty_min`, the duty is set to `duty_min`. It is held for `hold_lo` periods and the ramp then rises. If `hold_lo` = 0 it rises at once.
- R9: Field i of `step_word` and of `intv_word` is bits [4i+3:4i], for i = 0 to 7.
- R10: With `asym_mode` = 0, the field index is duty[7:5] on both the rising and the falling ramp.
- R11: With `asym_mode` = 1, the field index is {falling, duty[7:6]}, so rising ramps use fields 0 to 3 and falling ramps use fields 4 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 1 | Tick select: 1 = fast_en, 0 = slow_en |
| slow_en | input | 1 | Slow tick strobe, one cycle wide |
| fast_en | input | 1 | Fast tick strobe, one cycle wide |
| blink_mode | input | 1 | 1 = blinking mode, 0 = breathing mode |
| asym_mode | input | 1 | 1 = direction-dependent field selection |
| duty_min | input | 8 | Lower duty bound; duty value in blinking mode |
| duty_max | input | 8 | Upper duty bound |
| hold_hi | input | 8 | Periods spent at the upper bound |
| hold_lo | input | 8 | Periods spent at the lower bound; prescale reload in blinking mode |
| step_word | input | 32 | Eight packed 4-bit step sizes |
| intv_word | input | 32 | Eight packed 4-bit interval counts |
| led_out | output | 1 | LED drive |

## Verification
The bench builds the block with its default 8-bit duty and eight 4-bit fields. It drives the fast strobe on every cycle, so one breathing period is exactly 256 clocks. The observed duty is then simply the high count in each 256-clock window. A symmetric run and an asymmetric run of about a hundred periods each are compared against a period-level model. These runs cover both bound clamps, zero and non-zero dwell counts, and field selection that differs between the two directions. Blinking runs with a reload of 3 and a slow strobe at one quarter rate confirm the prescale factor and the tick selection, using windows of 1024 clocks.

// File: rtl/led_pkg.sv
package led_pkg;
    localparam int DUTY_W  = 8;
    localparam int FIELD_W = 4;
    localparam int NSEG    = 8;
    localparam int SEG_W   = $clog2(NSEG);
    localparam int WORD_W  = FIELD_W * NSEG;

    typedef enum logic [1:0] {
        PH_RISE    = 2'd0,
        PH_HOLD_HI = 2'd1,
        PH_FALL    = 2'd2,
        PH_HOLD_LO = 2'd3
    } ramp_phase_t;

    typedef struct packed {
        logic [FIELD_W-1:0] step;
        logic [FIELD_W-1:0] intv;
    } rate_t;

    function automatic logic [SEG_W-1:0] seg_pick(input logic asym, input logic falling,
                                                  input logic [DUTY_W-1:0] duty);
        if (asym)
            return {falling, duty[DUTY_W-1 -: SEG_W-1]};
        return duty[DUTY_W-1 -: SEG_W];
    endfunction

    function automatic logic [FIELD_W-1:0] field_of(input logic [WORD_W-1:0] word,
                                                    input logic [SEG_W-1:0] idx);
        return word[idx*FIELD_W +: FIELD_W];
    endfunction
endpackage

// File: rtl/led_prescaler.sv
module led_prescaler #(
    parameter int CW = led_pkg::DUTY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          tick,
    input  logic [CW-1:0] reload,
    output logic          pulse
);
    logic [CW-1:0] dly;

    always_ff @(posedge clk) begin
        if (rst || !enable)
            dly <= '0;
        else if (tick)
            dly <= (dly == '0) ? reload : dly - 1'b1;
    end

    assign pulse = enable && tick && (dly == '0);

    // R4
    pre_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && tick && dly == '0) |=> (!enable || dly == $past(reload)));
endmodule

// File: rtl/led_pwm.sv
module led_pwm #(
    parameter int DW = led_pkg::DUTY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [DW-1:0] duty,
    output logic          led,
    output logic          wrap
);
    localparam logic [DW-1:0] TOP = {DW{1'b1}};
    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end

    assign wrap = adv && (cnt == TOP);
    assign led  = (cnt < duty);

    // R5
    pwm_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));
    // R2
    led_zero_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !led);
    // R2
    pwm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));
endmodule

// File: rtl/led_ramp.sv
module led_ramp
    import led_pkg::*;
#(
    parameter int DW = DUTY_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          period_end,
    input  logic          asym,
    input  logic [DW-1:0] duty_min,
    input  logic [DW-1:0] duty_max,
    input  logic [DW-1:0] hold_hi,
    input  logic [DW-1:0] hold_lo,
    input  logic [WW-1:0] step_word,
    input  logic [WW-1:0] intv_word,
    output logic [DW-1:0] duty
);
    ramp_phase_t        phase;
    logic [FIELD_W-1:0] ivl_cnt;
    logic [DW-1:0]      hold_cnt;
    logic [SEG_W-1:0]   seg;
    rate_t              rate;
    logic [DW:0]        up_sum;
    logic [DW:0]        lo_lim;
    logic [DW:0]        hold_nxt;
    logic               ivl_done;

    assign seg      = seg_pick(asym, phase == PH_FALL, duty);
    assign rate     = '{step: field_of(step_word, seg), intv: field_of(intv_word, seg)};
    assign up_sum   = {1'b0, duty} + {{(DW+1-FIELD_W){1'b0}}, rate.step};
    assign lo_lim   = {1'b0, duty_min} + {{(DW+1-FIELD_W){1'b0}}, rate.step};
    assign hold_nxt = {1'b0, hold_cnt} + 1'b1;
    assign ivl_done = (ivl_cnt >= rate.intv);

    always_ff @(posedge clk) begin
        if (rst) begin
            duty     <= duty_min;
            phase    <= PH_RISE;
            ivl_cnt  <= '0;
            hold_cnt <= '0;
        end else if (run && period_end) begin
            unique case (phase)
                PH_RISE: begin
                    if (!ivl_done) begin
                        ivl_cnt <= ivl_cnt + 1'b1;
                    end else begin
                        ivl_cnt <= '0;
                        if (up_sum >= {1'b0, duty_max}) begin
                            duty     <= duty_max;
                            hold_cnt <= '0;
                            phase    <= (hold_hi == '0) ? PH_FALL : PH_HOLD_HI;
                        end else begin
                            duty <= up_sum[DW-1:0];
                        end
                    end
                end
                PH_HOLD_HI: begin
                    if (hold_nxt >= {1'b0, hold_hi}) begin
                        phase    <= PH_FALL;
                        hold_cnt <= '0;
                    end else begin
                        hold_cnt <= hold_nxt[DW-1:0];
                    end
                end
                PH_FALL: begin
                    if (!ivl_done) begin
                        ivl_cnt <= ivl_cnt + 1'b1;
                    end else begin
                        ivl_cnt <= '0;
                        if ({1'b0, duty} <= lo_lim) begin
                            duty     <= duty_min;
                            hold_cnt <= '0;
                            phase    <= (hold_lo == '0) ? PH_RISE : PH_HOLD_LO;
                        end else begin
                            duty <= duty - {{(DW-FIELD_W){1'b0}}, rate.step};
                        end
                    end
                end
                PH_HOLD_LO: begin
                    if (hold_nxt >= {1'b0, hold_lo}) begin
                        phase    <= PH_RISE;
                        hold_cnt <= '0;
                    end else begin
                        hold_cnt <= hold_nxt[DW-1:0];
                    end
                end
                default: phase <= PH_RISE;
            endcase
        end
    end

    // R6
    duty_period_only_chk: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(duty));
    // R6
    rise_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RISE && duty <= duty_max) |=> (duty >= $past(duty)));
    // R6
    fall_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FALL && duty >= duty_min) |=> (duty <= $past(duty)));
    // R7
    hold_hi_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD_HI) |=> $stable(duty));
    // R8
    hold_lo_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD_LO) |=> $stable(duty));
endmodule

// File: rtl/led_pulse_ctrl.sv
module led_pulse_ctrl
    import led_pkg::*;
#(
    parameter int DW = DUTY_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_sel,
    input  logic          slow_en,
    input  logic          fast_en,
    input  logic          blink_mode,
    input  logic          asym_mode,
    input  logic [DW-1:0] duty_min,
    input  logic [DW-1:0] duty_max,
    input  logic [DW-1:0] hold_hi,
    input  logic [DW-1:0] hold_lo,
    input  logic [WW-1:0] step_word,
    input  logic [WW-1:0] intv_word,
    output logic          led_out
);
    logic          sel_tick;
    logic          pre_pulse;
    logic          pwm_adv;
    logic          pwm_wrap;
    logic [DW-1:0] ramp_duty;
    logic [DW-1:0] act_duty;

    assign sel_tick = clk_sel ? fast_en : slow_en;
    assign pwm_adv  = blink_mode ? pre_pulse : sel_tick;
    assign act_duty = blink_mode ? duty_min : ramp_duty;

    led_prescaler #(.CW(DW)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .enable (blink_mode),
        .tick   (sel_tick),
        .reload (hold_lo),
        .pulse  (pre_pulse)
    );

    led_pwm #(.DW(DW)) u_pwm (
        .clk  (clk),
        .rst  (rst),
        .adv  (pwm_adv),
        .duty (act_duty),
        .led  (led_out),
        .wrap (pwm_wrap)
    );

    led_ramp #(.DW(DW), .WW(WW)) u_ramp (
        .clk        (clk),
        .rst        (rst),
        .run        (!blink_mode),
        .period_end (pwm_wrap),
        .asym       (asym_mode),
        .duty_min   (duty_min),
        .duty_max   (duty_max),
        .hold_hi    (hold_hi),
        .hold_lo    (hold_lo),
        .step_word  (step_word),
        .intv_word  (intv_word),
        .duty       (ramp_duty)
    );

    // R3
    tick_select_chk: assert property (@(posedge clk) disable iff (rst)
        (!blink_mode && !(clk_sel ? fast_en : slow_en)) |-> !pwm_adv);
endmodule

// File: tb/sim_led_pulse_ctrl.sv
module sim_led_pulse_ctrl;
    logic        clk = 0;
    logic        rst = 1;
    logic        clk_sel = 1, slow_en = 0, fast_en = 0;
    logic        blink_mode = 0, asym_mode = 0;
    logic [7:0]  duty_min = 0, duty_max = 0, hold_hi = 0, hold_lo = 0;
    logic [31:0] step_word = 0, intv_word = 0;
    logic        led_out;
    logic        slow_gen = 0;
    logic [1:0]  slow_ph = 0;
    int          checks = 0, errors = 0;
    bit          done = 0;

    typedef struct {
        int    exp;
        int    len;
        string tag;
    } item_t;
    item_t sbq[$];

    always #5 clk = ~clk;

    led_pulse_ctrl u0 (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .slow_en(slow_en), .fast_en(fast_en),
        .blink_mode(blink_mode), .asym_mode(asym_mode), .duty_min(duty_min),
        .duty_max(duty_max), .hold_hi(hold_hi), .hold_lo(hold_lo),
        .step_word(step_word), .intv_word(intv_word), .led_out(led_out)
    );

    always @(negedge clk) begin
        slow_ph <= slow_ph + 2'd1;
        slow_en <= slow_gen && (slow_ph == 2'd3);
    end

    task automatic push(input int e, input int l, input string t);
        item_t it;
        it.exp = e; it.len = l; it.tag = t;
        sbq.push_back(it);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic run_monitor();
        while (sbq.size() > 0) begin
            item_t it;
            int    hi;
            it = sbq.pop_front();
            hi = 0;
            for (int i = 0; i < it.len; i++) begin
                if (led_out) hi++;
                @(negedge clk);
            end
            checks++;
            if (hi != it.exp) begin
                errors++;
                $display("FAIL %s: high count %0d expected %0d", it.tag, hi, it.exp);
            end
        end
    endtask

    // Period-level model of the breathing ramp (R6 R7 R8 R9 R10 R11)
    task automatic gen_breath(input int n, input string tag);
        int d = duty_min, ph = 0, ivl = 0, hc = 0;
        for (int p = 0; p < n; p++) begin
            int idx, st, iv;
            push(d, 256, tag);
            if (asym_mode) idx = ((ph == 2) ? 4 : 0) + (d / 64);
            else           idx = d / 32;
            st = (step_word >> (4 * idx)) & 15;
            iv = (intv_word >> (4 * idx)) & 15;
            case (ph)
                0: if (ivl < iv) ivl++;
                   else begin
                       ivl = 0;
                       if (d + st >= duty_max) begin
                           d = duty_max; hc = 0; ph = (hold_hi == 0) ? 2 : 1;
                       end else d = d + st;
                   end
                1: begin hc++; if (hc >= hold_hi) begin ph = 2; hc = 0; end end
                2: if (ivl < iv) ivl++;
                   else begin
                       ivl = 0;
                       if (d <= duty_min + st) begin
                           d = duty_min; hc = 0; ph = (hold_lo == 0) ? 0 : 3;
                       end else d = d - st;
                   end
                default: begin hc++; if (hc >= hold_lo) begin ph = 0; hc = 0; end end
            endcase
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 R2: reset state, duty 0 keeps the pin low (blinking, reload 0)
        blink_mode = 1; clk_sel = 1; fast_en = 1; duty_min = 0; hold_lo = 0;
        push(0, 256, "R1 R2 reset/zero duty");
        do_reset(); run_monitor();

        // R4 R5: reload 0, full-scale duty, 8-bit period
        duty_min = 255;
        push(255, 256, "R4 R5 duty 255"); push(255, 256, "R5 second period");
        do_reset(); run_monitor();

        // R2 R5: quarter duty
        duty_min = 64;
        push(64, 256, "R2 R5 duty 64"); push(64, 256, "R2 R5 duty 64 repeat");
        do_reset(); run_monitor();

        // R4: prescale by hold_lo+1 = 4
        duty_min = 128; hold_lo = 3;
        push(512, 1024, "R4 prescale 4"); push(512, 1024, "R4 prescale 4 repeat");
        do_reset(); run_monitor();

        // R3: slow strobe selected, fast strobe idle
        hold_lo = 0; duty_min = 64; fast_en = 0; clk_sel = 0; slow_gen = 1;
        push(256, 1024, "R3 slow tick");
        do_reset(); run_monitor();

        // R3: fast selected while slow strobe keeps pulsing; fast held low -> counter frozen at 0
        clk_sel = 1;
        push(1024, 1024, "R3 unselected strobe ignored");
        do_reset(); run_monitor();
        slow_gen = 0; fast_en = 1;

        // Symmetric breathing: R1 R6 R7 R8 R9 R10
        blink_mode = 0; asym_mode = 0;
        duty_min = 16; duty_max = 200; hold_hi = 2; hold_lo = 1;
        step_word = 32'h6FDB9753; intv_word = 32'h10010201;
        gen_breath(100, "R1 R6 R7 R8 R9 R10 symmetric");
        do_reset(); run_monitor();

        // Asymmetric breathing with zero top dwell: R6 R7 R8 R9 R11
        asym_mode = 1; hold_hi = 0; hold_lo = 3;
        gen_breath(100, "R6 R7 R8 R9 R11 asymmetric");
        do_reset(); run_monitor();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule